// File: doc/BRIEF.md
# Edge-Triggered Capture Channel

This block samples an asynchronous input pin and, on a selected transition of that pin, stores the present value of a free-running counter into a capture register that software can only read. Rising and falling transitions each have their own enable, and both may be active together, so that every transition is recorded. A master enable gates the whole function. While it is low, no capture is taken and no flag is raised.

A load caused by the pin can raise a raw interrupt flag when the interrupt enable is set. The flag stays set until a clear strobe is applied. A clear strobe of 0 has no effect. The interrupt output is the flag, masked by the interrupt enable. The counter is produced outside this block. Routing the pin is also done outside this block.

Top module: `edge_capture_unit`

## Requirements
- R1: While reset is high, and on the first clock edge after reset, the capture register reads 0 and the flag and the interrupt are low.
- R2: With the master enable and the rising enable set, a 0-to-1 change on the pin loads the counter value into the capture register. The load happens on the third rising clock edge after the change: two edges pass through the synchroniser and one performs the load.
- R3: With the master enable and the falling enable set, a 1-to-0 change on the pin loads the counter value, with the same latency as R2.
- R4: A transition whose own edge enable is clear leaves the capture register unchanged, even when the other edge enable is set.
- R5: With both edge enables set, every transition of the pin, in either direction, causes a load.
- R6: With the master enable clear, no transition loads the capture register or raises the flag.
- R7: A pin-caused load sets the flag only while the interrupt enable is 1. With the interrupt enable at 0, the load still happens and the flag is not set.
- R8: A clear strobe of 1 lowers the flag on the next clock edge. While the strobe is 0, the flag keeps its value.
- R9: When a load that sets the flag and a clear strobe fall on the same clock edge, the flag is set after that edge.
- R10: The interrupt output is 1 exactly when the flag is set and the interrupt enable is 1.
- R11: The capture register changes only on a load. Between loads it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| count_i | input | CNT_W | Counter value to be captured |
| pin_i | input | 1 | Asynchronous external input |
| func_en_i | input | 1 | Master enable of the capture function |
| rise_en_i | input | 1 | Capture on a 0-to-1 transition |
| fall_en_i | input | 1 | Capture on a 1-to-0 transition |
| irq_en_i | input | 1 | Allow pin-caused loads to set the flag |
| flag_clr_i | input | 1 | Write-1 clear strobe for the flag |
| cap_o | output | CNT_W | Capture register |
| flag_o | output | 1 | Raw interrupt flag |
| irq_o | output | 1 | Interrupt request, the flag masked by the interrupt enable |

## Verification
A pin change made just after a falling clock edge shows up at the outputs on the third rising edge that follows. Two of those edges are spent in the synchroniser and the third performs the load. The flag follows on that same third edge. Each scenario therefore changes the pin at a falling edge, holds the counter constant through the window, waits three rising edges and samples at the next falling edge. A clear strobe takes effect on the first rising edge after it is applied. The coincidence case places the strobe in the cycle just before that third edge, so that the load and the clear land on the same edge.

// File: rtl/edge_cap_pkg.sv
package edge_cap_pkg;

    localparam int unsigned SYNC_DEPTH = 2;

    typedef struct packed {
        logic func_en;
        logic rise_en;
        logic fall_en;
        logic irq_en;
    } cap_ctrl_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic logic capture_hit(input cap_ctrl_t c, input edge_ev_t e);
        return c.func_en && ((c.rise_en && e.rise) || (c.fall_en && e.fall));
    endfunction

endpackage

// File: rtl/edge_cap_sync.sv
module edge_cap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[0] <= 1'b0;
                    else       chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[g] <= 1'b0;
                    else       chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[LAST];
endmodule

// File: rtl/edge_cap_detect.sv
module edge_cap_detect
    import edge_cap_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     level_i,
    output edge_ev_t ev_o
);
    logic prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= level_i;
    end

    always_comb begin
        ev_o.rise = level_i & ~prev_q;
        ev_o.fall = ~level_i & prev_q;
    end
endmodule

// File: rtl/edge_cap_flag.sv
module edge_cap_flag (
    input  logic clk_i,
    input  logic rst_i,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // set wins over a clear on the same edge
    always_ff @(posedge clk_i) begin
        if (rst_i)      flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import edge_cap_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             pin_i,
    input  logic             func_en_i,
    input  logic             rise_en_i,
    input  logic             fall_en_i,
    input  logic             irq_en_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             flag_o,
    output logic             irq_o
);
    cap_ctrl_t        ctrl;
    edge_ev_t         ev;
    logic             pin_sync;
    logic             load;
    logic             flag_set;
    logic [CNT_W-1:0] cap_q;

    always_comb begin
        ctrl.func_en = func_en_i;
        ctrl.rise_en = rise_en_i;
        ctrl.fall_en = fall_en_i;
        ctrl.irq_en  = irq_en_i;
    end

    edge_cap_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (pin_i),
        .q_o   (pin_sync)
    );

    edge_cap_detect u_detect (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (pin_sync),
        .ev_o    (ev)
    );

    assign load     = capture_hit(ctrl, ev);
    assign flag_set = load & ctrl.irq_en;

    always_ff @(posedge clk_i) begin
        if (rst_i)     cap_q <= '0;
        else if (load) cap_q <= count_i;
    end

    edge_cap_flag u_flag (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .set_i  (flag_set),
        .clr_i  (flag_clr_i),
        .flag_o (flag_o)
    );

    assign cap_o = cap_q;
    assign irq_o = flag_o & ctrl.irq_en;
endmodule

// File: rtl/edge_capture_unit_chk.sv
module edge_capture_unit_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             func_en_i,
    input logic             rise_en_i,
    input logic             fall_en_i,
    input logic             irq_en_i,
    input logic             flag_clr_i,
    input logic [CNT_W-1:0] cap_o,
    input logic             flag_o,
    input logic             irq_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        rst_i |=> (cap_o == '0 && !flag_o && !irq_o));

    // R6
    master_off_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !func_en_i |=> $stable(cap_o) && !$rose(flag_o));

    // R7
    no_irq_en_no_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!irq_en_i && !flag_o) |=> !flag_o);

    // R8
    flag_kept_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (flag_o && !flag_clr_i) |=> flag_o);

    // R10
    irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (flag_o && irq_en_i));

    // R11
    cap_change_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cap_o != $past(cap_o)) |-> ($past(func_en_i) && ($past(rise_en_i) || $past(fall_en_i))));
endmodule

bind edge_capture_unit edge_capture_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .func_en_i  (func_en_i),
    .rise_en_i  (rise_en_i),
    .fall_en_i  (fall_en_i),
    .irq_en_i   (irq_en_i),
    .flag_clr_i (flag_clr_i),
    .cap_o      (cap_o),
    .flag_o     (flag_o),
    .irq_o      (irq_o)
);

// File: tb/edge_capture_unit_bench.sv
`timescale 1ns/1ps
module edge_capture_unit_bench;
    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] count = '0;
    logic             pin = 1'b0;
    logic             func_en = 1'b0;
    logic             rise_en = 1'b0;
    logic             fall_en = 1'b0;
    logic             irq_en = 1'b0;
    logic             flag_clr = 1'b0;
    logic [CNT_W-1:0] cap;
    logic             flag;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    edge_capture_unit #(.CNT_W(CNT_W)) u_edge_capture_unit (
        .clk_i (clk), .rst_i (rst), .count_i (count), .pin_i (pin),
        .func_en_i (func_en), .rise_en_i (rise_en), .fall_en_i (fall_en),
        .irq_en_i (irq_en), .flag_clr_i (flag_clr),
        .cap_o (cap), .flag_o (flag), .irq_o (irq)
    );

    task automatic chk(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_ctrl(input logic f, input logic r, input logic fl, input logic ie);
        @(negedge clk);
        func_en = f; rise_en = r; fall_en = fl; irq_en = ie;
    endtask

    // pin changes after a falling edge; outputs due on the third rising edge
    task automatic move_pin(input logic v, input logic [CNT_W-1:0] cval);
        @(negedge clk);
        pin = v; count = cval;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        flag_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cap", cap, '0);
        chk("R1 flag", {31'd0, flag}, 0);
        chk("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_rise();
        set_ctrl(1, 1, 0, 1);
        move_pin(1'b1, 32'h1111_0001);
        chk("R2 rise load", cap, 32'h1111_0001);
        chk("R7 flag set", {31'd0, flag}, 1);
        chk("R10 irq on", {31'd0, irq}, 1);
        pulse_clear();
        chk("R8 clear", {31'd0, flag}, 0);
        chk("R10 irq off after clear", {31'd0, irq}, 0);
    endtask

    task automatic t_fall_ignored();
        move_pin(1'b0, 32'h2222_0002);
        chk("R4 fall ignored", cap, 32'h1111_0001);
        chk("R4 no flag", {31'd0, flag}, 0);
    endtask

    task automatic t_fall();
        set_ctrl(1, 0, 1, 1);
        move_pin(1'b1, 32'h3333_0003);
        chk("R4 rise ignored", cap, 32'h1111_0001);
        move_pin(1'b0, 32'h4444_0004);
        chk("R3 fall load", cap, 32'h4444_0004);
        chk("R3 flag", {31'd0, flag}, 1);
        pulse_clear();
    endtask

    task automatic t_both();
        set_ctrl(1, 1, 1, 0);
        move_pin(1'b1, 32'h5000_0001);
        chk("R5 rise", cap, 32'h5000_0001);
        move_pin(1'b0, 32'h5000_0002);
        chk("R5 fall", cap, 32'h5000_0002);
        move_pin(1'b1, 32'h5000_0003);
        chk("R5 rise again", cap, 32'h5000_0003);
        chk("R7 no flag when irq off", {31'd0, flag}, 0);
    endtask

    task automatic t_master_off();
        set_ctrl(0, 1, 1, 1);
        move_pin(1'b0, 32'h6000_0001);
        chk("R6 no load fall", cap, 32'h5000_0003);
        move_pin(1'b1, 32'h6000_0002);
        chk("R6 no load rise", cap, 32'h5000_0003);
        chk("R6 no flag", {31'd0, flag}, 0);
    endtask

    task automatic t_hold_and_mask();
        set_ctrl(1, 0, 1, 1);
        move_pin(1'b0, 32'h7000_0001);
        chk("R3 load", cap, 32'h7000_0001);
        @(negedge clk);
        count = 32'h7FFF_FFFF;
        repeat (6) @(negedge clk);
        chk("R8 flag held with clear 0", {31'd0, flag}, 1);
        chk("R11 cap held", cap, 32'h7000_0001);
        irq_en = 1'b0;
        #0.5;
        chk("R10 irq masked", {31'd0, irq}, 0);
        chk("R10 flag kept", {31'd0, flag}, 1);
        irq_en = 1'b1;
        #0.5;
        chk("R10 irq back", {31'd0, irq}, 1);
        pulse_clear();
    endtask

    task automatic t_coincide();
        set_ctrl(1, 1, 0, 1);
        @(negedge clk);
        pin = 1'b1; count = 32'h8000_0008;
        repeat (2) @(posedge clk);
        @(negedge clk);
        flag_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R9 set beats clear", {31'd0, flag}, 1);
        chk("R9 load", cap, 32'h8000_0008);
        pulse_clear();
        chk("R8 cleared", {31'd0, flag}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        t_reset();
        t_rise();
        t_fall_ignored();
        t_fall();
        t_both();
        t_master_off();
        t_hold_and_mask();
        t_coincide();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule